// File: doc/BRIEF.md
# Cache ECC Error Capture Logger

This block watches the check results produced when a SEC/DED-protected cache data array is read, and it keeps one error record for software. Each accepted beat describes one half-cacheline access. A beat carries the half-line index, the set number and, for each of its four 128-bit lanes, a single-error flag, a double-error flag, a 10-bit syndrome and the raw 10 stored check bits. The logger keeps two sticky status bits, one for corrected errors and one for uncorrectable errors. It also keeps a record of the failing access: index, set, a lane mask and one syndrome per lane. From these it drives two interrupt lines.

The record is first-come for single errors. A double error always takes the record, unless an earlier double error already holds it. Software clears the status bits by writing ones to them, and clearing them re-arms capture. For diagnostics, software can turn ECC checking off and turn diagnostic capture on. Loads tagged as coming from the diagnostic requester then copy the raw check bits of one chosen half cacheline into the syndrome registers.

Beats arrive on a valid/ready stream. `chk_ready` is high at all times, so the logger never applies back-pressure. A beat counts in the cycle where `chk_valid` is high. Registers are read through a combinational port and written in one cycle.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, every register reads zero, both interrupts are low and `chk_ready` is high.
- R2: While the ECC enable bit (control bit 0) is clear, error flags in beats change neither the status bits nor the record.
- R3: A beat with a single error on any lane and no double error sets status bit 8. If status bits 8 and 9 were both clear, it also captures the index (address register bits 10:0), the set (bits 18:16), the lane mask of the flagged lanes (bits 23:20, bit n = lane n) and all four syndromes. Syndrome register 2 holds lane 0 in bits 9:0 and lane 1 in bits 25:16. Register 3 holds lanes 2 and 3 in the same positions.
- R4: A single-error beat that arrives while either status bit is set leaves the record unchanged.
- R5: A double-error beat sets status bit 9 and captures a new record, replacing any single-error record, when bit 9 was clear. While bit 9 is set, later double errors leave the record unchanged.
- R6: When a beat flags single and double errors together, it is handled as a double error only. The lane mask shows the double-error lanes, and status bit 8 is not set by that beat.
- R7: Writing register 0 with bit 8 or bit 9 set clears that status bit. Writing zero there leaves it unchanged. If an error arrives in the same cycle as the clear, the error wins. Once both bits are clear, the next error is captured.
- R8: `sec_irq` is status bit 8 AND enable bit 1. `ded_irq` is status bit 9 AND enable bit 2. Both follow the register state in the same cycle.
- R9: A diagnostic capture requires all of the following: ECC enable clear, diagnostic enable (bit 3) set, `chk_diag` high, and index bit 0 equal to the half-select bit (bit 4). The beat then copies `chk_raw` into the four syndrome registers and leaves the address register and status untouched. In any other case, `chk_raw` is ignored.
- R10: Register 0 reads back control bits 4:0 as written, with the status in bits 9:8. Unused bits read zero.
- R11: `chk_ready` stays high. Flags presented while `chk_valid` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Beat valid |
| chk_ready | output | 1 | Beat ready, always high |
| chk_index | input | IDX_W | Half-cacheline index, bit 0 selects the half |
| chk_set | input | SET_W | Set number |
| chk_sec | input | 4 | Per-lane single-error flags |
| chk_ded | input | 4 | Per-lane double-error flags |
| chk_syn | input | 4*SYN_W | Per-lane syndromes, lane 0 lowest |
| chk_raw | input | 4*SYN_W | Per-lane raw check bits, lane 0 lowest |
| chk_diag | input | 1 | Beat is a load from the diagnostic requester |
| reg_addr | input | 2 | Register select (0 control/status, 1 address, 2 and 3 syndromes) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| sec_irq | output | 1 | Corrected-error interrupt |
| ded_irq | output | 1 | Uncorrectable-error interrupt |

## Verification
The bench uses the default widths: an 11-bit index, a 3-bit set and 10-bit syndromes. This lets it drive the all-ones index, set 7 and syndrome patterns that fill each 10-bit slot, so a field-placement slip shows up in the read-back. A behavioural model follows every status bit and record field and is compared on every clock. Directed sequences cover the overwrite rules, same-cycle precedence, clear-versus-event races and both diagnostic halves. A random phase then mixes beats and control writes.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int LANES     = 4;
  localparam int REG_W     = 32;
  localparam int SLOT_W    = 16;
  // control register bit positions
  localparam int C_ECC_EN  = 0;
  localparam int C_SEC_IE  = 1;
  localparam int C_DED_IE  = 2;
  localparam int C_DIAG    = 3;
  localparam int C_HALF    = 4;
  localparam int S_SEC     = 8;
  localparam int S_DED     = 9;
  // address register field positions
  localparam int A_SET_LSB  = 16;
  localparam int A_MASK_LSB = 20;

  typedef enum logic [1:0] {
    RS_CTRL  = 2'd0,
    RS_ADDR  = 2'd1,
    RS_SYN_A = 2'd2,
    RS_SYN_B = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_SEC  = 2'd1,
    EV_DED  = 2'd2
  } ev_kind_e;

  // packed so that bit n matches control register bit n
  typedef struct packed {
    logic half_sel;
    logic diag_en;
    logic ded_ie;
    logic sec_ie;
    logic ecc_en;
  } ctrl_t;
endpackage

// File: rtl/ecc_log_classify.sv
module ecc_log_classify
  import ecc_log_pkg::*;
#(
  parameter int N = LANES
) (
  input  logic         beat,
  input  logic [N-1:0] sec,
  input  logic [N-1:0] ded,
  output ev_kind_e     kind,
  output logic [N-1:0] mask
);
  // double error outranks single error on the same beat
  always_comb begin
    kind = EV_NONE;
    mask = '0;
    if (beat) begin
      if (|ded) begin
        kind = EV_DED;
        mask = ded;
      end else if (|sec) begin
        kind = EV_SEC;
        mask = sec;
      end
    end
  end
endmodule

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  ctrl_t    ctrl_new,
  input  logic     clr_sec,
  input  logic     clr_ded,
  input  ev_kind_e kind,
  output ctrl_t    ctrl,
  output logic     sts_sec,
  output logic     sts_ded,
  output logic     capture,
  output logic     sec_irq,
  output logic     ded_irq
);
  logic do_clr_sec, do_clr_ded;

  assign do_clr_sec = we & clr_sec;
  assign do_clr_ded = we & clr_ded;

  // record is taken by a first single error or by a double error over no double
  assign capture = ((kind == EV_DED) && !sts_ded) ||
                   ((kind == EV_SEC) && !sts_sec && !sts_ded);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      sts_sec <= 1'b0;
      sts_ded <= 1'b0;
    end else begin
      if (we) ctrl <= ctrl_new;
      sts_sec <= (kind == EV_SEC) | (sts_sec & ~do_clr_sec);
      sts_ded <= (kind == EV_DED) | (sts_ded & ~do_clr_ded);
    end
  end

  assign sec_irq = sts_sec & ctrl.sec_ie;
  assign ded_irq = sts_ded & ctrl.ded_ie;

  // R7: a clear with no competing event leaves the bit low
  assert_w1c_ded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_clr_ded && kind != EV_DED) |=> !sts_ded);
  assert_w1c_sec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_clr_sec && kind != EV_SEC) |=> !sts_sec);
endmodule

// File: rtl/ecc_log_record.sv
module ecc_log_record
  import ecc_log_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int SET_W = 3,
  parameter int SYN_W = 10,
  parameter int N     = LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             diag_cap,
  input  logic [IDX_W-1:0] idx,
  input  logic [SET_W-1:0] set,
  input  logic [N-1:0]     mask,
  input  logic [N*SYN_W-1:0] syn,
  input  logic [N*SYN_W-1:0] raw,
  output logic [IDX_W-1:0] rec_idx,
  output logic [SET_W-1:0] rec_set,
  output logic [N-1:0]     rec_mask,
  output logic [N*SYN_W-1:0] rec_syn
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_idx  <= '0;
      rec_set  <= '0;
      rec_mask <= '0;
    end else if (capture) begin
      rec_idx  <= idx;
      rec_set  <= set;
      rec_mask <= mask;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        rec_syn[g*SYN_W +: SYN_W] <= '0;
      else if (capture)
        rec_syn[g*SYN_W +: SYN_W] <= syn[g*SYN_W +: SYN_W];
      else if (diag_cap)
        rec_syn[g*SYN_W +: SYN_W] <= raw[g*SYN_W +: SYN_W];
    end
  end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int SET_W = 3,
  parameter int SYN_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chk_valid,
  output logic                   chk_ready,
  input  logic [IDX_W-1:0]       chk_index,
  input  logic [SET_W-1:0]       chk_set,
  input  logic [3:0]             chk_sec,
  input  logic [3:0]             chk_ded,
  input  logic [4*SYN_W-1:0]     chk_syn,
  input  logic [4*SYN_W-1:0]     chk_raw,
  input  logic                   chk_diag,
  input  logic [1:0]             reg_addr,
  input  logic                   reg_we,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic                   sec_irq,
  output logic                   ded_irq
);
  localparam int SYN_ALL = LANES * SYN_W;

  ev_kind_e           kind;
  logic [LANES-1:0]   ev_mask;
  ctrl_t              ctrl;
  logic               sts_sec, sts_ded, capture, diag_cap, ctl_we;
  logic [IDX_W-1:0]   rec_idx;
  logic [SET_W-1:0]   rec_set;
  logic [LANES-1:0]   rec_mask;
  logic [SYN_ALL-1:0] rec_syn;
  logic               wdata_unused;

  assign chk_ready    = 1'b1;
  assign ctl_we       = reg_we && (reg_sel_e'(reg_addr) == RS_CTRL);
  assign wdata_unused = ^{reg_wdata[REG_W-1:S_DED+1], reg_wdata[S_SEC-1:C_HALF+1]};

  ecc_log_classify #(.N(LANES)) u_classify (
    .beat (chk_valid & ctrl.ecc_en),
    .sec  (chk_sec),
    .ded  (chk_ded),
    .kind (kind),
    .mask (ev_mask)
  );

  ecc_log_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ctl_we),
    .ctrl_new (ctrl_t'(reg_wdata[C_HALF:C_ECC_EN])),
    .clr_sec  (reg_wdata[S_SEC]),
    .clr_ded  (reg_wdata[S_DED]),
    .kind     (kind),
    .ctrl     (ctrl),
    .sts_sec  (sts_sec),
    .sts_ded  (sts_ded),
    .capture  (capture),
    .sec_irq  (sec_irq),
    .ded_irq  (ded_irq)
  );

  assign diag_cap = chk_valid && !ctrl.ecc_en && ctrl.diag_en && chk_diag &&
                    (chk_index[0] == ctrl.half_sel);

  ecc_log_record #(.IDX_W(IDX_W), .SET_W(SET_W), .SYN_W(SYN_W), .N(LANES)) u_record (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .diag_cap (diag_cap),
    .idx      (chk_index),
    .set      (chk_set),
    .mask     (ev_mask),
    .syn      (chk_syn),
    .raw      (chk_raw),
    .rec_idx  (rec_idx),
    .rec_set  (rec_set),
    .rec_mask (rec_mask),
    .rec_syn  (rec_syn)
  );

  // read mux: two lanes per syndrome register, even lane low
  always_comb begin
    reg_rdata = '0;
    case (reg_sel_e'(reg_addr))
      RS_CTRL: begin
        reg_rdata[C_HALF:C_ECC_EN] = ctrl;
        reg_rdata[S_SEC]           = sts_sec;
        reg_rdata[S_DED]           = sts_ded;
      end
      RS_ADDR: begin
        reg_rdata[IDX_W-1:0]             = rec_idx;
        reg_rdata[A_SET_LSB +: SET_W]    = rec_set;
        reg_rdata[A_MASK_LSB +: LANES]   = rec_mask;
      end
      default: begin
        for (int k = 0; k < LANES; k++) begin
          if (reg_addr[0] == k[1])
            reg_rdata[(k % 2) * SLOT_W +: SYN_W] = rec_syn[k*SYN_W +: SYN_W];
        end
      end
    endcase
  end

  // R2: with checking off and no write, status cannot move
  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.ecc_en && !reg_we) |=> ($stable(sts_sec) && $stable(sts_ded)));
  // R4: single error over an existing record keeps it
  assert_sec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && ctrl.ecc_en && !(|chk_ded) && (|chk_sec) && (sts_sec || sts_ded))
      |=> ($stable(rec_idx) && $stable(rec_syn) && $stable(rec_mask)));
  // R5: first double error takes the record
  assert_ded_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && ctrl.ecc_en && (|chk_ded) && !sts_ded)
      |=> (rec_idx == $past(chk_index) && rec_mask == $past(chk_ded)));
  // R6: combined beat never raises the single-error bit
  assert_ded_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && ctrl.ecc_en && (|chk_ded) && !sts_sec) |=> !sts_sec);
  // R9: diagnostic load copies raw check bits
  assert_diag_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !ctrl.ecc_en && ctrl.diag_en && chk_diag && (chk_index[0] == ctrl.half_sel))
      |=> (rec_syn == $past(chk_raw) && $stable(rec_idx)));
endmodule

// File: tb/test_ecc_err_logger.sv
module test_ecc_err_logger;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_valid;
  logic        chk_ready;
  logic [10:0] chk_index;
  logic [2:0]  chk_set;
  logic [3:0]  chk_sec, chk_ded;
  logic [39:0] chk_syn, chk_raw;
  logic        chk_diag;
  logic [1:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sec_irq, ded_irq;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ecc_err_logger i_ecc_err_logger (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_index(chk_index), .chk_set(chk_set), .chk_sec(chk_sec), .chk_ded(chk_ded),
    .chk_syn(chk_syn), .chk_raw(chk_raw), .chk_diag(chk_diag),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sec_irq(sec_irq), .ded_irq(ded_irq)
  );

  // reference model state
  logic        m_ecc, m_sie, m_die, m_diag, m_half, m_ssec, m_sded;
  logic [10:0] m_idx;
  logic [2:0]  m_set;
  logic [3:0]  m_mask;
  logic [39:0] m_syn;

  task automatic model_reset();
    {m_ecc, m_sie, m_die, m_diag, m_half, m_ssec, m_sded} = '0;
    m_idx = '0; m_set = '0; m_mask = '0; m_syn = '0;
  endtask

  // one clock of behaviour, computed from the inputs held over the edge
  task automatic model_step();
    logic n_ssec, n_sded;
    n_ssec = m_ssec; n_sded = m_sded;
    if (reg_we && reg_addr == 2'd0) begin
      if (reg_wdata[8]) n_ssec = 1'b0;
      if (reg_wdata[9]) n_sded = 1'b0;
    end
    if (chk_valid && m_ecc) begin
      if (chk_ded != 0) begin
        n_sded = 1'b1;
        if (!m_sded) begin
          m_idx = chk_index; m_set = chk_set; m_mask = chk_ded; m_syn = chk_syn;
        end
      end else if (chk_sec != 0) begin
        n_ssec = 1'b1;
        if (!m_ssec && !m_sded) begin
          m_idx = chk_index; m_set = chk_set; m_mask = chk_sec; m_syn = chk_syn;
        end
      end
    end else if (chk_valid && m_diag && chk_diag && chk_index[0] == m_half) begin
      m_syn = chk_raw;
    end
    if (reg_we && reg_addr == 2'd0) begin
      m_ecc = reg_wdata[0]; m_sie = reg_wdata[1]; m_die = reg_wdata[2];
      m_diag = reg_wdata[3]; m_half = reg_wdata[4];
    end
    m_ssec = n_ssec; m_sded = n_sded;
  endtask

  function automatic logic [31:0] exp_reg(int a);
    logic [31:0] w;
    w = '0;
    case (a)
      0: begin
        w[0] = m_ecc; w[1] = m_sie; w[2] = m_die; w[3] = m_diag; w[4] = m_half;
        w[8] = m_ssec; w[9] = m_sded;
      end
      1: begin w[10:0] = m_idx; w[18:16] = m_set; w[23:20] = m_mask; end
      2: begin w[9:0] = m_syn[9:0];   w[25:16] = m_syn[19:10]; end
      default: begin w[9:0] = m_syn[29:20]; w[25:16] = m_syn[39:30]; end
    endcase
    return w;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(req, "irq", {30'b0, ded_irq, sec_irq}, {30'b0, m_sded & m_die, m_ssec & m_sie});
    check("R11", "ready", {31'b0, chk_ready}, 32'd1);
    for (int a = 0; a < 4; a++) begin
      reg_addr = a[1:0];
      #1;
      check(req, $sformatf("reg%0d", a), reg_rdata, exp_reg(a));
    end
  endtask

  task automatic tick(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic quiet();
    chk_valid = 0; chk_sec = 0; chk_ded = 0; chk_diag = 0; reg_we = 0;
  endtask

  task automatic beat(string req, logic [10:0] idx, logic [2:0] st, logic [3:0] s,
                      logic [3:0] d, logic [39:0] syn, logic [39:0] raw, logic dg);
    quiet();
    chk_valid = 1; chk_index = idx; chk_set = st; chk_sec = s; chk_ded = d;
    chk_syn = syn; chk_raw = raw; chk_diag = dg;
    tick(req);
    quiet();
  endtask

  task automatic wctl(string req, logic [31:0] d);
    quiet();
    reg_we = 1; reg_addr = 2'd0; reg_wdata = d;
    tick(req);
    quiet();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; quiet();
    chk_index = '0; chk_set = '0; chk_syn = '0; chk_raw = '0;
    reg_addr = '0; reg_wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1;
    tick("R1");

    // R2: checking off, errors ignored
    beat("R2", 11'h123, 3'd1, 4'b0001, 4'b0000, 40'h12345_6789A, 40'h0, 0);
    beat("R2", 11'h124, 3'd2, 4'b0000, 4'b1000, 40'hFFFFF_FFFFF, 40'h0, 0);
    // R10: enable ECC and both interrupts, readback of control field
    wctl("R10", 32'h0000_0007);
    // R11: flags without valid ignored
    quiet(); chk_sec = 4'hF; chk_ded = 4'hF; tick("R11"); quiet();
    // R3: first single error
    beat("R3", 11'h7FF, 3'd7, 4'b0100, 4'b0000, 40'h3FF00_2AA55, 40'h0, 0);
    // R4: second single error leaves record
    beat("R4", 11'h001, 3'd0, 4'b0001, 4'b0000, 40'h11111_22222, 40'h0, 0);
    // R5: double overwrites single record, then is sticky
    beat("R5", 11'h2A5, 3'd5, 4'b0000, 4'b1001, 40'hABCDE_01234, 40'h0, 0);
    beat("R5", 11'h0F0, 3'd3, 4'b0000, 4'b0010, 40'h55555_AAAAA, 40'h0, 0);
    beat("R4", 11'h0F1, 3'd3, 4'b0010, 4'b0000, 40'h00001_00001, 40'h0, 0);
    // R7: clear single only, write zero leaves, then clear double
    wctl("R7", 32'h0000_0107);
    wctl("R7", 32'h0000_0007);
    wctl("R7", 32'h0000_0207);
    // R7: re-armed capture
    beat("R7", 11'h400, 3'd4, 4'b1000, 4'b0000, 40'h0BEEF_0CAFE, 40'h0, 0);
    wctl("R7", 32'h0000_0307);
    // R6: same-cycle single and double
    beat("R6", 11'h3C3, 3'd6, 4'b0011, 4'b0100, 40'hFEDCB_A9876, 40'h0, 0);
    // R7: clear racing a new double error -> error wins
    quiet();
    reg_we = 1; reg_addr = 2'd0; reg_wdata = 32'h0000_0207;
    chk_valid = 1; chk_index = 11'h055; chk_set = 3'd2; chk_ded = 4'b0001; chk_syn = 40'h1;
    tick("R7");
    quiet();
    // R8: interrupt enables gate outputs without touching status
    wctl("R8", 32'h0000_0001);
    beat("R8", 11'h00A, 3'd1, 4'b0001, 4'b0000, 40'h2, 40'h0, 0);
    wctl("R8", 32'h0000_0003);
    wctl("R8", 32'h0000_0005);
    wctl("R8", 32'h0000_0307);
    // R9: diagnostic capture, half select 1
    wctl("R9", 32'h0000_0018);
    beat("R9", 11'h011, 3'd0, 4'b0000, 4'b0000, 40'h0, 40'h3FF_00155, 1);
    beat("R9", 11'h012, 3'd0, 4'b0000, 4'b0000, 40'h0, 40'h12345_54321, 1);
    beat("R9", 11'h013, 3'd0, 4'b1111, 4'b1111, 40'h0, 40'h0AAAA_BBBBB, 0);
    wctl("R9", 32'h0000_0008);
    beat("R9", 11'h012, 3'd0, 4'b0000, 4'b0000, 40'h0, 40'hCCCCC_DDDDD, 1);
    beat("R9", 11'h013, 3'd0, 4'b0000, 4'b0000, 40'h0, 40'h99999_88888, 1);
    // R9: ECC on blocks diagnostic path
    wctl("R9", 32'h0000_0019);
    beat("R9", 11'h013, 3'd0, 4'b0000, 4'b0000, 40'h0, 40'h77777_66666, 1);

    // random mix (R5 rules together with R3, R4, R7)
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 2) begin
        logic [31:0] d;
        d = $urandom;
        d[0] = ($urandom % 4) != 0;
        wctl("R5", d);
      end else begin
        logic [3:0] s, dd;
        s  = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
        dd = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
        beat("R5", 11'($urandom), 3'($urandom), s, dd,
             {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
        if (($urandom % 2) == 0) begin
          chk_valid = 0; tick("R11");
        end
      end
    end
    finish_run();
  end
endmodule